// File: doc/BRIEF.md
# Big-Endian Narrow Load/Store Aligner

This block sits between a 32-bit processor datapath and a memory that is one word wide. Every address names a single 8-bit byte, and lanes follow big-endian order: the byte at the lowest address of a word is its most significant byte. The block handles byte, halfword and word accesses.

For loads, the datapath presents the fetched word together with the access size and the low address bits. The block picks out the addressed byte or halfword and widens it to 32 bits. Signed loads copy the top bit of the selected data into the upper bits, and unsigned loads fill the upper bits with zeros. The result is registered, so it appears one cycle after the request. For stores, the block copies the low bits of the source register into every lane of the write bus. It then raises only the byte enables of the lanes the access targets. An access whose address does not suit its size is flagged, and the flagged access writes nothing and returns no load result.

Top module: `be_lsu_aligner`

## Requirements
- R1: While `rstN` is low, `loadValid` and `loadData` are 0.
- R2: A byte access at offset k (k = 0..3) uses lane bits [31-8k:24-8k]. For a store, this is `memByteEn` bit 3-k alone.
- R3: A signed load (`reqUnsigned`=0) of a byte or halfword fills bits above the selected data with that data's top bit. A halfword at offset 0 comes from bits [31:16], and one at offset 2 comes from bits [15:0].
- R4: An unsigned load (`reqUnsigned`=1) of a byte or halfword fills the bits above the selected data with zeros.
- R5: A word load (`reqSize`=10) returns the fetched word unchanged, whatever `reqUnsigned` is.
- R6: `memWdata` is a continuous function of `reqSize` and `storeSrc`. For size 00 it is source bits [7:0] copied into all four lanes. For size 01 it is source bits [15:0] copied into both halves. For any other size it is the source word.
- R7: A valid, aligned store drives `memByteEn` to 1100 for a halfword at offset 0, to 0011 for a halfword at offset 2, and to 1111 for a word. A load or an idle cycle drives 0000.
- R8: A valid request raises `misalign` if it is a word with a nonzero offset, a halfword with an odd offset, or uses the reserved size 11. Such a request drives `memByteEn` to 0000 and produces no `loadValid`.
- R9: `loadValid` is high in the cycle after a valid, aligned load and low otherwise. `loadData` keeps its value until the next such load.
- R10: `misalign` stays low whenever `reqValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | An access is requested this cycle |
| reqLoad | input | 1 | 1 = load, 0 = store |
| reqSize | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| reqUnsigned | input | 1 | Zero-extend a narrow load instead of sign-extending it |
| reqByteOff | input | 2 | Low address bits: byte offset within the word |
| storeSrc | input | 32 | Source register value for a store |
| memRdata | input | 32 | Word read from memory for the current load |
| memWdata | output | 32 | Write data with narrow data copied into the lanes |
| memByteEn | output | 4 | Per-lane write enables; bit 3 is offset 0 |
| misalign | output | 1 | The valid request is misaligned or uses the reserved size |
| loadData | output | 32 | Aligned, extended load result (registered) |
| loadValid | output | 1 | `loadData` was updated by the previous cycle's load |

## Verification
`misalign`, `memByteEn` and `memWdata` are due in the same cycle as the request. `loadData` and `loadValid` are due one clock edge later. The bench drives each request just after a falling edge and checks the combinational results 1 ns later, against a reference computed from the inputs of that cycle. At the next rising edge it records what the load registers should hold. It compares those registered values at the following falling edge, so each result is sampled only after the one register on its path has updated.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic     capture;  // load result must be registered this cycle
    logic     signExt;  // narrow load copies its top bit upward
    accSize_e size;     // decoded access width
  } alignCtrl_t;

endpackage

// File: rtl/lsu_align_ctrl.sv
module lsu_align_ctrl
  import lsu_align_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = 2
) (
  input  logic             reqValid,
  input  logic             reqLoad,
  input  logic [1:0]       reqSize,
  input  logic             reqUnsigned,
  input  logic [OFF_W-1:0] reqByteOff,
  output alignCtrl_t       ctrl,
  output logic             misalign,
  output logic [LANES-1:0] byteEn
);

  accSize_e         sizeE;
  logic             badAlign;
  logic             okAccess;
  logic [LANES-1:0] laneMask;

  always_comb begin
    sizeE = accSize_e'(reqSize);
    unique case (sizeE)
      SZ_BYTE: badAlign = 1'b0;
      SZ_HALF: badAlign = reqByteOff[0];
      SZ_WORD: badAlign = (reqByteOff != '0);
      default: badAlign = 1'b1;
    endcase
    okAccess = reqValid && !badAlign;
    misalign = reqValid && badAlign;

    ctrl.capture = okAccess && reqLoad;
    ctrl.signExt = !reqUnsigned;
    ctrl.size    = sizeE;
  end

  // Lane k of the word (byte offset k) maps to enable bit LANES-1-k
  always_comb begin
    laneMask = '0;
    for (int k = 0; k < LANES; k++) begin
      unique case (sizeE)
        SZ_BYTE: laneMask[LANES-1-k] = (OFF_W'(k) == reqByteOff);
        SZ_HALF: laneMask[LANES-1-k] = (OFF_W'(k >> 1) == (reqByteOff >> 1));
        SZ_WORD: laneMask[LANES-1-k] = 1'b1;
        default: laneMask[LANES-1-k] = 1'b0;
      endcase
    end
    byteEn = (okAccess && !reqLoad) ? laneMask : '0;
  end

endmodule

// File: rtl/lsu_align_dp.sv
module lsu_align_dp
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  alignCtrl_t        ctrl,
  input  logic [OFF_W-1:0]  reqByteOff,
  input  logic [DATA_W-1:0] storeSrc,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadData,
  output logic              loadValid
);

  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;

  logic [OFF_W-1:0]  halfOff;
  logic [BYTE_W-1:0] pickByte;
  logic [HALF_W-1:0] pickHalf;
  logic [DATA_W-1:0] extended;

  // Store path: narrow data copied into every lane it could occupy
  always_comb begin
    unique case (ctrl.size)
      SZ_BYTE: memWdata = {LANES{storeSrc[BYTE_W-1:0]}};
      SZ_HALF: memWdata = {(LANES / 2){storeSrc[HALF_W-1:0]}};
      default: memWdata = storeSrc;
    endcase
  end

  // Load path: big-endian lane pick, offset 0 is the top byte
  always_comb begin
    halfOff  = {reqByteOff[OFF_W-1:1], 1'b0};
    pickByte = memRdata[BYTE_W * (LANES - 1 - int'(reqByteOff)) +: BYTE_W];
    pickHalf = memRdata[BYTE_W * (LANES - 2 - int'(halfOff)) +: HALF_W];
    unique case (ctrl.size)
      SZ_BYTE: extended = {{(DATA_W - BYTE_W){ctrl.signExt & pickByte[BYTE_W-1]}}, pickByte};
      SZ_HALF: extended = {{(DATA_W - HALF_W){ctrl.signExt & pickHalf[HALF_W-1]}}, pickHalf};
      default: extended = memRdata;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadValid <= 1'b0;
      loadData  <= '0;
    end else begin
      loadValid <= ctrl.capture;
      if (ctrl.capture) loadData <= extended;
    end
  end

endmodule

// File: rtl/be_lsu_aligner.sv
module be_lsu_aligner
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqLoad,
  input  logic [1:0]        reqSize,
  input  logic              reqUnsigned,
  input  logic [1:0]        reqByteOff,
  input  logic [DATA_W-1:0] storeSrc,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic              misalign,
  output logic [DATA_W-1:0] loadData,
  output logic              loadValid
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  alignCtrl_t ctrlS;

  lsu_align_ctrl #(.LANES(LANES), .OFF_W(OFF_W)) ctrlI (
    .reqValid    (reqValid),
    .reqLoad     (reqLoad),
    .reqSize     (reqSize),
    .reqUnsigned (reqUnsigned),
    .reqByteOff  (reqByteOff[OFF_W-1:0]),
    .ctrl        (ctrlS),
    .misalign    (misalign),
    .byteEn      (memByteEn)
  );

  lsu_align_dp #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) dpI (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrlS),
    .reqByteOff (reqByteOff[OFF_W-1:0]),
    .storeSrc   (storeSrc),
    .memRdata   (memRdata),
    .memWdata   (memWdata),
    .loadData   (loadData),
    .loadValid  (loadValid)
  );

endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqLoad,
  input logic [1:0]          reqSize,
  input logic                misalign,
  input logic [DATA_W/8-1:0] memByteEn,
  input logic [DATA_W-1:0]   loadData,
  input logic                loadValid
);

  logic goodLoad;
  assign goodLoad = reqValid && reqLoad && !misalign;

  // R8
  misalign_no_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (memByteEn == '0));

  // R7
  load_no_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqLoad || !reqValid) |-> (memByteEn == '0));

  // R2
  byte_store_single_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqLoad && reqSize == 2'b00) |-> ($countones(memByteEn) == 1));

  // R9
  load_valid_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    goodLoad |=> loadValid);

  // R9
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !goodLoad |=> !loadValid);

  // R9
  load_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !goodLoad |=> $stable(loadData));

  // R10
  idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !misalign);

endmodule

bind be_lsu_aligner lsu_align_chk #(.DATA_W(DATA_W)) chkI (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqLoad   (reqLoad),
  .reqSize   (reqSize),
  .misalign  (misalign),
  .memByteEn (memByteEn),
  .loadData  (loadData),
  .loadValid (loadValid)
);

// File: tb/be_lsu_aligner_test.sv
module be_lsu_aligner_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqLoad = 1'b0;
  logic [1:0]  reqSize = 2'b00;
  logic        reqUnsigned = 1'b0;
  logic [1:0]  reqByteOff = 2'b00;
  logic [31:0] storeSrc = '0;
  logic [31:0] memRdata = '0;
  logic [31:0] memWdata;
  logic [3:0]  memByteEn;
  logic        misalign;
  logic [31:0] loadData;
  logic        loadValid;

  int total = 0;
  int bad = 0;

  logic [31:0] expData = '0;
  logic        expValid = 1'b0;
  string       expTag = "R1";

  always #5 clk = ~clk;

  be_lsu_aligner uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLoad(reqLoad),
    .reqSize(reqSize), .reqUnsigned(reqUnsigned), .reqByteOff(reqByteOff),
    .storeSrc(storeSrc), .memRdata(memRdata), .memWdata(memWdata),
    .memByteEn(memByteEn), .misalign(misalign), .loadData(loadData),
    .loadValid(loadValid)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit refMis(bit v, bit [1:0] sz, bit [1:0] off);
    if (!v) return 1'b0;
    if (sz == 2'd3) return 1'b1;
    if (sz == 2'd2) return off != 0;
    if (sz == 2'd1) return off[0];
    return 1'b0;
  endfunction

  function automatic logic [31:0] refLoad(bit [1:0] sz, bit un, bit [1:0] off, logic [31:0] rd);
    logic [31:0] v;
    if (sz == 2'd0) begin
      v = (rd >> (8 * (3 - int'(off)))) & 32'hFF;
      if (!un && v[7]) v = v | 32'hFFFF_FF00;
    end else if (sz == 2'd1) begin
      v = (rd >> (8 * (2 - int'(off)))) & 32'hFFFF;
      if (!un && v[15]) v = v | 32'hFFFF_0000;
    end else begin
      v = rd;
    end
    return v;
  endfunction

  function automatic logic [3:0] refBe(bit v, bit ld, bit [1:0] sz, bit [1:0] off);
    if (!v || ld || refMis(v, sz, off)) return 4'b0000;
    if (sz == 2'd0) return 4'b1000 >> off;
    if (sz == 2'd1) return (off == 0) ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] refWdata(bit [1:0] sz, logic [31:0] src);
    if (sz == 2'd0) return {24'h0, src[7:0]} * 32'h0101_0101;
    if (sz == 2'd1) return {16'h0, src[15:0]} * 32'h0001_0001;
    return src;
  endfunction

  task automatic step(input bit v, input bit ld, input bit [1:0] sz, input bit un,
                      input bit [1:0] off, input logic [31:0] src, input logic [31:0] rd);
    bit mis;
    @(negedge clk);
    reqValid = v; reqLoad = ld; reqSize = sz; reqUnsigned = un;
    reqByteOff = off; storeSrc = src; memRdata = rd;
    #1;
    // registered results of the previous cycle's request
    check(loadValid == expValid, "R9", "loadValid", 32'(loadValid), 32'(expValid));
    check(loadData == expData, expValid ? expTag : "R9", "loadData", loadData, expData);
    // same-cycle results
    mis = refMis(v, sz, off);
    check(misalign == mis, v ? "R8" : "R10", "misalign", 32'(misalign), 32'(mis));
    check(memByteEn == refBe(v, ld, sz, off), (sz == 2'd0) ? "R2" : "R7", "memByteEn",
          32'(memByteEn), 32'(refBe(v, ld, sz, off)));
    check(memWdata == refWdata(sz, src), "R6", "memWdata", memWdata, refWdata(sz, src));
    @(posedge clk);
    if (v && ld && !mis) begin
      expValid = 1'b1;
      expData  = refLoad(sz, un, off, rd);
      expTag   = (sz == 2'd2) ? "R5" : (sz == 2'd0 && !un) ? "R2" : un ? "R4" : "R3";
    end else begin
      expValid = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset with a load request present: nothing may be captured
    reqValid = 1'b1; reqLoad = 1'b1; reqSize = 2'd2; memRdata = 32'hDEAD_BEEF;
    repeat (3) begin
      @(negedge clk); #1;
      check(loadValid == 1'b0, "R1", "loadValid in reset", 32'(loadValid), 32'h0);
      check(loadData == 32'h0, "R1", "loadData in reset", loadData, 32'h0);
    end
    @(negedge clk);
    reqValid = 1'b0;
    rstN = 1'b1;

    // byte loads, signed and unsigned, each lane
    for (int k = 0; k < 4; k++) step(1, 1, 2'd0, 0, 2'(k), 32'h0, 32'h80F1_7F02);
    for (int k = 0; k < 4; k++) step(1, 1, 2'd0, 1, 2'(k), 32'h0, 32'h80F1_7F02);
    // halfword loads
    step(1, 1, 2'd1, 0, 2'd0, 32'h0, 32'h9234_7ABC);
    step(1, 1, 2'd1, 0, 2'd2, 32'h0, 32'h9234_7ABC);
    step(1, 1, 2'd1, 0, 2'd2, 32'h0, 32'h1234_FABC);
    step(1, 1, 2'd1, 1, 2'd0, 32'h0, 32'h9234_FABC);
    step(1, 1, 2'd1, 1, 2'd2, 32'h0, 32'h9234_FABC);
    // word loads, unsigned flag has no effect
    step(1, 1, 2'd2, 0, 2'd0, 32'h0, 32'hF00D_CAFE);
    step(1, 1, 2'd2, 1, 2'd0, 32'h0, 32'h8000_0001);
    // stores of every size and lane
    for (int k = 0; k < 4; k++) step(1, 0, 2'd0, 0, 2'(k), 32'h1122_33A5, 32'h0);
    step(1, 0, 2'd1, 0, 2'd0, 32'hAABB_CCDD, 32'h0);
    step(1, 0, 2'd1, 0, 2'd2, 32'hAABB_CCDD, 32'h0);
    step(1, 0, 2'd2, 0, 2'd0, 32'h0123_4567, 32'h0);
    // misaligned and reserved-size requests
    step(1, 1, 2'd1, 0, 2'd1, 32'h0, 32'h5555_AAAA);
    step(1, 0, 2'd1, 0, 2'd3, 32'hFFFF_FFFF, 32'h0);
    for (int k = 1; k < 4; k++) step(1, 1, 2'd2, 0, 2'(k), 32'h0, 32'h7777_7777);
    step(1, 0, 2'd2, 0, 2'd2, 32'h1357_9BDF, 32'h0);
    step(1, 0, 2'd3, 0, 2'd0, 32'h2468_ACE0, 32'h0);
    step(1, 1, 2'd3, 1, 2'd0, 32'h0, 32'h1111_2222);
    // idle cycles with bad alignment: no flag, result held
    step(0, 1, 2'd2, 0, 2'd3, 32'h0, 32'h9999_9999);
    step(0, 0, 2'd1, 0, 2'd1, 32'hFFFF_0000, 32'h0);
    step(0, 0, 2'd3, 0, 2'd0, 32'h0, 32'h0);
    // mixed traffic
    for (int i = 0; i < 400; i++)
      step(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
           $urandom, $urandom);
    step(0, 0, 2'd0, 0, 2'd0, 32'h0, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule